// File: doc/BRIEF.md
# Run-Length Pixel Stream Expander

This block turns a compressed byte stream back into the pixels of one image frame. The compressed stream is a sequence of runs. Each run takes two bytes: first the pixel value, then the number of times that value repeats. The block takes these bytes over a valid/ready stream from a buffer that holds checked payloads. It sends pixels out over a second valid/ready stream, which normally feeds a dual-clock FIFO towards the display. When that FIFO cannot take data, the output stalls, and the input stalls with it.

The block counts every pixel it hands over. Once it has delivered one full frame of `FRAME_W` × `FRAME_H` pixels (640 × 480 by default), it raises a frame-complete flag. After that point it still drains the incoming bytes but emits nothing more. It raises an overflow flag if any pixels had to be discarded for that reason.

Top module: `rle_pixel_expander`

## Requirements
- R1: After a synchronous active-low reset, out_valid, frame_done and overflow are 0 and in_ready is 1.
- R2: Accepted input bytes alternate. The first byte after reset, and the first byte after each run, is the pixel value. The next byte is the repetition count.
- R3: A count byte N in 1..255 produces exactly N output pixels, all equal to the run's value byte.
- R4: A count byte of 0 produces exactly 256 output pixels.
- R5: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_pixel stays unchanged. A pixel is consumed only in a cycle where both are 1.
- R6: While a run is being emitted (out_valid is 1), in_ready is 0 and no input byte is accepted.
- R7: frame_done becomes 1 once FRAME_W × FRAME_H pixels have been handed over, and it stays 1 until reset. It is 0 before that point.
- R8: After frame_done, in_ready stays 1 and further byte pairs are accepted but produce no output. The count byte of such a pair sets overflow.
- R9: A run that reaches past the frame budget is cut at the budget. Exactly FRAME_W × FRAME_H pixels are emitted in total, and overflow is set. A run that ends exactly on the budget leaves overflow at 0.
- R10: A reset in the middle of a run discards the rest of that run, clears the pixel count, and returns the byte parser to expecting a value byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | BYTE_W | Compressed byte (a value or a count) |
| out_valid | output | 1 | Output pixel is present |
| out_ready | input | 1 | Downstream takes the pixel |
| out_pixel | output | BYTE_W | Decoded pixel value |
| frame_done | output | 1 | Full frame has been delivered (sticky) |
| overflow | output | 1 | Pixels were discarded after or at the frame budget (sticky) |

## Verification
The hardest situations to reach are the two at the frame budget: a run that lands exactly on the last pixel, and a run that straddles it. To hit them, the bench builds the design with a small 32 × 20 frame. It then chooses run lengths whose sum comes to exactly 640, or goes past 640 by a known amount. Every count byte from 1 through 0 (meaning 256) is swept with a fresh reset per run. Meanwhile out_ready follows an irregular pattern, so that stalls occur mid-run and the hold and count-only-on-handshake rules are exercised on every run length.

// File: rtl/rle_pkg.sv
// Shared types for the run-length pixel expander.
// Assumes: nothing beyond the standard language.
package rle_pkg;
    // Which byte of a pair the parser expects next.
    typedef enum logic {
        EXPECT_VALUE = 1'b0,
        EXPECT_COUNT = 1'b1
    } pair_state_t;
endpackage

// File: rtl/rle_pair_parser.sv
// Splits the incoming byte stream into (value, count) pairs.
// Assumes: bytes arrive strictly as value-then-count. The parser holds
// off input (in_ready low) while the emitter is busy with a run. A count
// byte of zero is widened to 2**BYTE_W repetitions.
module rle_pair_parser
    import rle_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int LEN_W = BYTE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              run_busy,
    output logic              pair_done,
    output logic [BYTE_W-1:0] pair_value,
    output logic [LEN_W-1:0]  pair_len
);
    pair_state_t state_q;
    logic [BYTE_W-1:0] value_q;
    logic accept;

    // Input is held off for as long as a run is being emitted.
    assign in_ready = !run_busy;
    assign accept   = in_valid && in_ready;

    // A pair is complete when its count byte is accepted.
    assign pair_done  = accept && (state_q == EXPECT_COUNT);
    assign pair_value = value_q;

    // Widen the count byte; zero stands for the largest run.
    always_comb begin
        if (in_data == '0)
            pair_len = LEN_W'(1) << BYTE_W;
        else
            pair_len = {1'b0, in_data};
    end

    // Track which byte of the pair comes next and latch the value byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EXPECT_VALUE;
            value_q <= '0;
        end else if (accept) begin
            if (state_q == EXPECT_VALUE) begin
                value_q <= in_data;
                state_q <= EXPECT_COUNT;
            end else begin
                state_q <= EXPECT_VALUE;
            end
        end
    end

    // R2: a value byte is always followed by a count byte.
    a_r2_value_then_count: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && state_q == EXPECT_VALUE) |=> (state_q == EXPECT_COUNT));
    // R2: after a count byte the parser expects a value byte again.
    a_r2_count_then_value: assert property (@(posedge clk) disable iff (!rst_n)
        pair_done |=> (state_q == EXPECT_VALUE));
endmodule

// File: rtl/rle_frame_tracker.sv
// Counts the pixels handed downstream against the per-frame budget.
// Assumes: pix_fire pulses once for each pixel transferred. The emitter
// never fires once frame_done is high.
module rle_frame_tracker #(
    parameter int FRAME_W = 640,
    parameter int FRAME_H = 480,
    localparam int FRAME_PIX = FRAME_W * FRAME_H,
    localparam int CNT_W = $clog2(FRAME_PIX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_fire,
    output logic last_pixel,
    output logic frame_done
);
    logic [CNT_W-1:0] count_q;

    assign last_pixel = (count_q == CNT_W'(FRAME_PIX - 1));
    assign frame_done = (count_q == CNT_W'(FRAME_PIX));

    // Advance the pixel count on each transfer, saturating at the budget.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (pix_fire && !frame_done)
            count_q <= count_q + 1'b1;
    end

    // R7: the count never passes the budget.
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(FRAME_PIX));
    // R7: once the frame is complete it stays complete.
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> frame_done);
endmodule

// File: rtl/rle_run_emitter.sv
// Repeats the current run's value on a valid/ready output.
// Assumes: load and pix fire never coincide, because loads only happen
// while idle. It stops at the frame budget and records overflow when
// pixels are discarded.
module rle_run_emitter #(
    parameter int BYTE_W = 8,
    localparam int LEN_W = BYTE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pair_done,
    input  logic [BYTE_W-1:0] pair_value,
    input  logic [LEN_W-1:0]  pair_len,
    input  logic              last_pixel,
    input  logic              frame_done,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_pixel,
    output logic              pix_fire,
    output logic              overflow
);
    logic              busy_q;
    logic [LEN_W-1:0]  left_q;
    logic [BYTE_W-1:0] pix_q;
    logic              ovf_q;
    logic              load;
    logic              drop;

    assign out_valid = busy_q;
    assign out_pixel = pix_q;
    assign overflow  = ovf_q;
    assign pix_fire  = busy_q && out_ready;
    assign load      = pair_done && !frame_done;
    assign drop      = pair_done && frame_done;

    // Load a new run, or count down one repetition per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            left_q <= '0;
            pix_q  <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            left_q <= pair_len;
            pix_q  <= pair_value;
        end else if (pix_fire) begin
            left_q <= left_q - 1'b1;
            if (left_q == LEN_W'(1) || last_pixel)
                busy_q <= 1'b0;
        end
    end

    // Record discarded pixels: whole pairs after the frame, or a cut run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (drop || (pix_fire && last_pixel && left_q != LEN_W'(1)))
            ovf_q <= 1'b1;
    end

    // R5: a stalled pixel stays presented and unchanged.
    a_r5_hold_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pixel)));
    // R5: the repetition count moves only on a transfer.
    a_r5_count_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !out_ready) |=> $stable(left_q));
    // R9: overflow is sticky.
    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: rtl/rle_pixel_expander.sv
// Top level: run-length byte stream in, pixel stream out, one frame budget.
// Assumes: input bytes come as (value, count) pairs. The output feeds a
// FIFO that may deassert out_ready at any time. A reset starts a new frame.
module rle_pixel_expander #(
    parameter int BYTE_W  = 8,
    parameter int FRAME_W = 640,
    parameter int FRAME_H = 480,
    localparam int LEN_W = BYTE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_pixel,
    output logic              frame_done,
    output logic              overflow
);
    logic              pair_done;
    logic [BYTE_W-1:0] pair_value;
    logic [LEN_W-1:0]  pair_len;
    logic              pix_fire;
    logic              last_pixel;

    rle_pair_parser #(.BYTE_W(BYTE_W)) u_parser (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .run_busy   (out_valid),
        .pair_done  (pair_done),
        .pair_value (pair_value),
        .pair_len   (pair_len)
    );

    rle_run_emitter #(.BYTE_W(BYTE_W)) u_emitter (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair_done  (pair_done),
        .pair_value (pair_value),
        .pair_len   (pair_len),
        .last_pixel (last_pixel),
        .frame_done (frame_done),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_pixel  (out_pixel),
        .pix_fire   (pix_fire),
        .overflow   (overflow)
    );

    rle_frame_tracker #(.FRAME_W(FRAME_W), .FRAME_H(FRAME_H)) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_fire   (pix_fire),
        .last_pixel (last_pixel),
        .frame_done (frame_done)
    );

    // R6: no byte is taken while a run is on the output.
    a_r6_stall_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
    // R8: nothing is emitted once the frame is complete.
    a_r8_silent_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !out_valid);
    // R1: the cycle after reset is idle and clean.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !frame_done && !overflow));
endmodule

// File: tb/sim_rle_pixel_expander.sv
module sim_rle_pixel_expander;
    localparam int FW = 32;
    localparam int FH = 20;
    localparam int FPIX = FW * FH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic out_ready = 1'b0;
    logic in_ready, out_valid, frame_done, overflow;
    logic [7:0] out_pixel;
    int checks = 0;
    int errors = 0;

    rle_pixel_expander #(.BYTE_W(8), .FRAME_W(FW), .FRAME_H(FH)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_pixel(out_pixel), .frame_done(frame_done), .overflow(overflow)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b);
        int guard = 0;
        @(negedge clk);
        in_valid = 1'b1; in_data = b;
        while (!in_ready && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Drain output with an irregular ready pattern; checks R3/R5/R6 facts.
    task automatic drain(input int exp_n, input logic [7:0] exp_v, input int seed,
                         input string req);
        int got = 0, badv = 0, badh = 0, badr = 0, idle = 0, cyc = 0;
        bit hold_pend = 0;
        logic [7:0] hold_v = '0;
        bit r;
        while (idle < 2 && cyc < 4000) begin
            if (cyc != 0) @(negedge clk);
            cyc++;
            if (hold_pend && (!out_valid || out_pixel != hold_v)) badh++;
            if (out_valid && in_ready) badr++;
            r = ((cyc * 3 + seed) % 5) != 0;
            out_ready = r;
            if (out_valid && r) begin
                got++;
                if (out_pixel != exp_v) badv++;
            end
            hold_pend = out_valid && !r;
            hold_v = out_pixel;
            if (!out_valid) idle++; else idle = 0;
        end
        out_ready = 1'b0;
        check(got == exp_n, req, got, exp_n);
        check(badv == 0, "R3 pixel value", badv, 0);
        check(badh == 0, "R5 hold under stall", badh, 0);
        check(badr == 0, "R6 in_ready low while emitting", badr, 0);
    endtask

    initial begin
        #(2_000_000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1: reset state
        check(out_valid == 0, "R1 out_valid", out_valid, 0);
        check(in_ready == 1, "R1 in_ready", in_ready, 1);
        check(frame_done == 0, "R1 frame_done", frame_done, 0);
        check(overflow == 0, "R1 overflow", overflow, 0);

        // R2 R3 R4: sweep every count byte, fresh frame each time
        for (int n = 1; n <= 256; n++) begin
            logic [7:0] v;
            v = 8'((n * 37 + 11) & 255);
            do_reset();
            send_byte(v);
            send_byte(8'(n & 255));
            drain(n, v, n, (n == 256) ? "R4 zero count means 256" : "R2 R3 run length");
            check(frame_done == 0, "R7 not done below budget", frame_done, 0);
        end

        // R7 R9: runs that end exactly on the budget (255+255+130 = 640)
        do_reset();
        send_byte(8'd1); send_byte(8'd255); drain(255, 8'd1, 1, "R7 run a");
        check(frame_done == 0, "R7 not done early", frame_done, 0);
        send_byte(8'd2); send_byte(8'd255); drain(255, 8'd2, 2, "R7 run b");
        send_byte(8'd3); send_byte(8'd130); drain(130, 8'd3, 3, "R7 run c");
        check(frame_done == 1, "R7 done at budget", frame_done, 1);
        check(overflow == 0, "R9 exact fit no overflow", overflow, 0);
        // R8: a pair after the frame is taken but emits nothing
        check(in_ready == 1, "R8 in_ready after done", in_ready, 1);
        send_byte(8'd4); send_byte(8'd5); drain(0, 8'd4, 4, "R8 no output after done");
        check(overflow == 1, "R8 overflow after extra pair", overflow, 1);
        check(frame_done == 1, "R7 done sticky", frame_done, 1);

        // R9: straddling run is cut (255+255+200, only 130 of last emitted)
        do_reset();
        send_byte(8'd7); send_byte(8'd255); drain(255, 8'd7, 5, "R9 run a");
        send_byte(8'd8); send_byte(8'd255); drain(255, 8'd8, 6, "R9 run b");
        check(overflow == 0, "R9 no overflow before cut", overflow, 0);
        send_byte(8'd9); send_byte(8'd200);
        drain(FPIX - 510, 8'd9, 7, "R9 run cut at budget");
        check(frame_done == 1, "R9 done after cut", frame_done, 1);
        check(overflow == 1, "R9 overflow after cut", overflow, 1);

        // R10: reset mid-run
        do_reset();
        send_byte(8'h55); send_byte(8'd100);
        out_ready = 1'b1;
        for (int k = 0; k < 10; k++) @(negedge clk);
        out_ready = 1'b0;
        check(out_valid == 1, "R10 run in progress", out_valid, 1);
        do_reset();
        @(negedge clk);
        check(out_valid == 0, "R10 run discarded", out_valid, 0);
        check(in_ready == 1, "R10 in_ready after reset", in_ready, 1);
        check(overflow == 0, "R10 overflow cleared", overflow, 0);
        send_byte(8'd9); send_byte(8'd3); drain(3, 8'd9, 8, "R10 parser expects value");
        send_byte(8'd1); send_byte(8'd255); drain(255, 8'd1, 9, "R10 refill a");
        send_byte(8'd2); send_byte(8'd255); drain(255, 8'd2, 10, "R10 refill b");
        send_byte(8'd3); send_byte(8'd126); drain(126, 8'd3, 11, "R10 refill c");
        check(frame_done == 0, "R10 count restarted", frame_done, 0);
        send_byte(8'd4); send_byte(8'd1); drain(1, 8'd4, 12, "R10 last pixel");
        check(frame_done == 1, "R10 done at full count", frame_done, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule